// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low handshake lines from a modem: clear to send, data set ready, ring indicator and carrier detect. It presents them to a processor as one 8-bit status byte. The upper nibble gives the present state of each line, inverted so that an asserted line reads as 1. The lower nibble holds sticky flags that record changes on the lines since the status byte was last read. Every line passes through a synchroniser before any edge is compared, so the pins may be driven from any clock domain.

Three of the flags record a transition in either direction. The ring flag is different: it records only the end of a ring, which is when the pin returns from low to high. A processor read clears all flags on the clock edge that ends the read cycle. An interrupt request is raised while any flag is set and the interrupt enable input is high.

Top module: `modem_status_monitor`

## Requirements
- R1: statusOut bits 4, 5, 6 and 7 show the inverted synchronised level of clearToSendN, dataSetReadyN, ringIndN and carrierDetN in that order. Each bit settles two clock edges after its pin changes, and this holds during reset as well.
- R2: statusOut bits 0, 1 and 3 are change flags for clear to send, data set ready and carrier detect. A flag becomes 1 one edge after its status bit changes, whether that change is a rise or a fall.
- R3: statusOut bit 2 becomes 1 only when ringIndN goes from low to high, which is when status bit 6 falls. A high-to-low change on ringIndN leaves bit 2 at 0.
- R4: Once set, a change flag stays at 1 on every following edge until a read takes place.
- R5: While rdStrobe is high, statusOut shows the current byte. The edge that ends a read cycle clears all four change flags.
- R6: A change detected in the same cycle as a read leaves its flag at 1 after the read. Flags without a new change are cleared.
- R7: irq is 1 exactly when msIntEn is 1 and at least one change flag is 1.
- R8: While rstN is low, all change flags are 0 and irq is 0, and bits 4 to 7 keep following the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset of the change flags |
| clearToSendN | input | 1 | Clear-to-send line, active low |
| dataSetReadyN | input | 1 | Data-set-ready line, active low |
| ringIndN | input | 1 | Ring indicator line, active low |
| carrierDetN | input | 1 | Carrier detect line, active low |
| rdStrobe | input | 1 | High for one cycle per processor read of the status byte |
| msIntEn | input | 1 | Modem-status interrupt enable |
| statusOut | output | 8 | Line states in bits 7:4, change flags in bits 3:0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
A stale edge reference or a wrong synchroniser depth shows at the ports in one of two ways. Either a status bit moves on the wrong edge, or a change flag appears a cycle early, a cycle late, or not at all. Both are visible within three edges of a pin change. A wrong clear priority shows on the edge right after a read: either a flag that changed during the read disappears, or a flag with no new change survives. A ring detector with the wrong polarity raises bit 2 and irq when the ring starts instead of when it ends. This is visible within three edges of the pin falling.

// File: rtl/msm_pkg.sv
package msm_pkg;
  localparam int NUM_LINES = 4;
  localparam int RING_IDX  = 2;

  typedef struct packed {
    logic clearFlags;
  } msmCtrl_t;
endpackage

// File: rtl/msm_datapath.sv
module msm_datapath
  import msm_pkg::*;
#(
  parameter int LINES       = NUM_LINES,
  parameter int SYNC_STAGES = 2,
  parameter int RING_LINE   = RING_IDX
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] linesN,
  input  msmCtrl_t         ctrl,
  output logic [LINES-1:0] lineState,
  output logic [LINES-1:0] flags
);
  localparam int TOP = SYNC_STAGES - 1;

  for (genvar g = 0; g < LINES; g++) begin : gLine
    logic [SYNC_STAGES-1:0] chain;
    logic                   prevQ;
    logic                   hit;
    logic                   flagQ;

    always_ff @(posedge clk) begin
      chain <= {chain[TOP-1:0], linesN[g]};
      prevQ <= chain[TOP];
    end

    if (g == RING_LINE) begin : gTrail
      assign hit = ~prevQ & chain[TOP];
    end else begin : gAny
      assign hit = prevQ ^ chain[TOP];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ <= 1'b0;
      else       flagQ <= (flagQ & ~ctrl.clearFlags) | hit;
    end

    assign lineState[g] = ~chain[TOP];
    assign flags[g]     = flagQ;
  end
endmodule

// File: rtl/msm_control.sv
module msm_control
  import msm_pkg::*;
#(
  parameter int LINES = NUM_LINES
) (
  input  logic             rdStrobe,
  input  logic             intEnable,
  input  logic [LINES-1:0] flags,
  output msmCtrl_t         ctrl,
  output logic             irq
);
  always_comb begin
    ctrl.clearFlags = rdStrobe;
    irq             = intEnable & (|flags);
  end
endmodule

// File: rtl/modem_status_monitor.sv
module modem_status_monitor
  import msm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       clearToSendN,
  input  logic       dataSetReadyN,
  input  logic       ringIndN,
  input  logic       carrierDetN,
  input  logic       rdStrobe,
  input  logic       msIntEn,
  output logic [7:0] statusOut,
  output logic       irq
);
  logic [NUM_LINES-1:0] lineState;
  logic [NUM_LINES-1:0] flags;
  msmCtrl_t             ctrl;

  msm_datapath #(.LINES(NUM_LINES), .SYNC_STAGES(SYNC_STAGES), .RING_LINE(RING_IDX)) dp_i (
    .clk(clk), .rstN(rstN),
    .linesN({carrierDetN, ringIndN, dataSetReadyN, clearToSendN}),
    .ctrl(ctrl), .lineState(lineState), .flags(flags)
  );

  msm_control #(.LINES(NUM_LINES)) ctl_i (
    .rdStrobe(rdStrobe), .intEnable(msIntEn), .flags(flags),
    .ctrl(ctrl), .irq(irq)
  );

  assign statusOut = {lineState, flags};
endmodule

// File: rtl/modem_status_monitor_chk.sv
module modem_status_monitor_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic       clk,
  input logic       rstN,
  input logic       clearToSendN,
  input logic       dataSetReadyN,
  input logic       ringIndN,
  input logic       carrierDetN,
  input logic       rdStrobe,
  input logic       msIntEn,
  input logic [7:0] statusOut,
  input logic       irq
);
  logic [3:0] pinsN;
  assign pinsN = {carrierDetN, ringIndN, dataSetReadyN, clearToSendN};

  p_line_follow_r1: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[7:4] == ~$past(pinsN, SYNC_STAGES));

  p_cts_delta_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOut[4]) |=> statusOut[0]);
  p_dsr_delta_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOut[5]) |=> statusOut[1]);
  p_dcd_delta_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(statusOut[7]) |=> statusOut[3]);

  p_ring_trail_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statusOut[6]) |=> statusOut[2]);
  p_ring_lead_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(statusOut[6]) && !statusOut[2]) |=> !statusOut[2]);

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |=> ((statusOut[3:0] & $past(statusOut[3:0])) == $past(statusOut[3:0])));

  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && $stable(statusOut[7:4])) |=> statusOut[3:0] == 4'b0000);

  p_irq_enable_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> msIntEn);

  always_comb begin
    if (!rstN) begin
      p_reset_quiet_r8: assert (statusOut[3:0] == 4'b0000 && !irq);
    end
  end
endmodule

bind modem_status_monitor modem_status_monitor_chk #(.SYNC_STAGES(SYNC_STAGES)) chk_i (
  .clk(clk), .rstN(rstN), .clearToSendN(clearToSendN), .dataSetReadyN(dataSetReadyN),
  .ringIndN(ringIndN), .carrierDetN(carrierDetN), .rdStrobe(rdStrobe),
  .msIntEn(msIntEn), .statusOut(statusOut), .irq(irq)
);

// File: tb/modem_status_monitor_tb_top.sv
module modem_status_monitor_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] pinsN = 4'b1111;   // {carrier, ring, dsr, cts}, active low
  logic       rdStrobe = 1'b0;
  logic       msIntEn = 1'b0;
  logic [7:0] statusOut;
  logic       irq;
  int         errors = 0;
  int         checks = 0;

  always #5 clk = ~clk;

  modem_status_monitor dut_i (
    .clk(clk), .rstN(rstN),
    .clearToSendN(pinsN[0]), .dataSetReadyN(pinsN[1]),
    .ringIndN(pinsN[2]), .carrierDetN(pinsN[3]),
    .rdStrobe(rdStrobe), .msIntEn(msIntEn),
    .statusOut(statusOut), .irq(irq)
  );

  // Vector: pins, enable, expected status before read, expected irq, read afterwards
  typedef struct packed {
    logic [3:0] pins;
    logic       en;
    logic [7:0] expStat;
    logic       expIrq;
    logic       doRead;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'b1111, 1'b0, 8'h00, 1'b0, 1'b0},
    '{4'b1110, 1'b0, 8'h11, 1'b0, 1'b1},
    '{4'b1110, 1'b1, 8'h10, 1'b0, 1'b0},
    '{4'b1111, 1'b1, 8'h01, 1'b1, 1'b1},
    '{4'b1011, 1'b1, 8'h40, 1'b0, 1'b0},
    '{4'b1111, 1'b1, 8'h04, 1'b1, 1'b1},
    '{4'b1101, 1'b1, 8'h22, 1'b1, 1'b0},
    '{4'b0101, 1'b1, 8'hAA, 1'b1, 1'b1},
    '{4'b0101, 1'b0, 8'hA0, 1'b0, 1'b0},
    '{4'b1111, 1'b0, 8'h0A, 1'b0, 1'b1}
  };

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReadPulse();
    rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R8: reset behaviour, lines follow pins, flags and irq quiet
    msIntEn = 1'b1;
    pinsN = 4'b1010;
    waitNeg(4);
    check8("R8 status during reset", statusOut, 8'h50);
    check8("R8 irq during reset", {7'b0, irq}, 8'h00);
    pinsN = 4'b1111;
    waitNeg(4);
    check8("R8 flags stay clear in reset, R1 follow", statusOut, 8'h00);
    check8("R8 irq stays low in reset", {7'b0, irq}, 8'h00);
    msIntEn = 1'b0;
    rstN = 1'b1;
    waitNeg(2);
    check8("R8 no flag after reset release", statusOut, 8'h00);

    // Table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      pinsN   = VECS[v].pins;
      msIntEn = VECS[v].en;
      waitNeg(4);
      check8($sformatf("R1/R2/R3/R4 vector %0d status", v), statusOut, VECS[v].expStat);
      check8($sformatf("R7 vector %0d irq", v), {7'b0, irq}, {7'b0, VECS[v].expIrq});
      if (VECS[v].doRead) begin
        doReadPulse();
        check8($sformatf("R5 vector %0d after read", v), statusOut, {VECS[v].expStat[7:4], 4'b0000});
      end
    end

    // R2: change and return before read leaves flag set
    msIntEn = 1'b1;
    pinsN = 4'b1101;
    waitNeg(1);
    pinsN = 4'b1111;
    waitNeg(4);
    check8("R2 pulse on dsr latched", statusOut, 8'h02);
    check8("R7 irq with flag and enable", {7'b0, irq}, 8'h01);
    doReadPulse();

    // R3: ring start alone never sets bit 2
    pinsN = 4'b1011;
    waitNeg(6);
    check8("R3 ring start ignored", statusOut, 8'h40);
    check8("R3 no irq on ring start", {7'b0, irq}, 8'h00);
    pinsN = 4'b1111;
    waitNeg(4);
    doReadPulse();

    // R6 and R5: read in the cycle the cts change is detected
    pinsN = 4'b1101;
    waitNeg(4);
    check8("R6 setup dsr flag", statusOut, 8'h22);
    pinsN = 4'b1100;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rdStrobe = 1'b1;
    check8("R5 value shown during read", statusOut, 8'h32);
    @(negedge clk);
    rdStrobe = 1'b0;
    check8("R6 concurrent change kept, old flag cleared", statusOut, 8'h31);
    waitNeg(3);
    check8("R4 flag still held", statusOut, 8'h31);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule